// File: doc/BRIEF.md
# Shared-Memory Burst Write Sequencer

This block sits on the slave side of a local processor bus and turns processor burst writes into write cycles on an SRAM that the processor shares with a second master. A request begins with an address cycle. In that cycle the processor drops its address strobe and chip select, drives the write direction and the start word address, and presents the byte enables. Two fixed cycles follow, one for arbitration and one for bus recovery. The block then takes one data word per clock with no wait states. It acknowledges each word with an active-low ready.

Every accepted word is registered. In the following cycle it appears on the memory port with its word address, the chip select and the write strobes. The internal word address is a full counter. A burst may start at any word offset, advances by one per word and carries into the upper address bits. A memory-organisation input chooses between per-byte write strobes, which follow the captured byte enables, and a single common write strobe.

Top module: `shmw_top`

## Requirements
- R1: While reset is active, and after it is released, `cpu_rdy_n`, `mem_cs_n`, `mem_we_all_n` and `mem_oe_n` are 1 and `mem_we_n` is all ones.
- R2: A write request is accepted in a cycle where `cpu_as_n`=0, `cpu_cs_n`=0 and `cpu_wr`=1 while the block is idle. `cpu_rdy_n` stays 1 in the two cycles after that address cycle. It first goes to 0 in the third cycle after it.
- R3: Once ready has dropped, `cpu_rdy_n` stays 0 on consecutive cycles, one cycle per word, with no wait cycle in between.
- R4: The burst ends on the data cycle in which `cpu_last_n`=0 is sampled, or after the fourth word, whichever comes first. `cpu_rdy_n` is 1 in the cycle after the final word.
- R5: The word taken in a ready cycle appears on `mem_wdata` in the following cycle, together with its address and its write strobes.
- R6: Consecutive memory beats have word addresses that differ by +1, starting from `cpu_addr` as captured in the address cycle. The start offset can be any value. The count carries past a four-word boundary.
- R7: With `ram_mode`=0, each beat drives `mem_we_n` = bitwise NOT of `cpu_be` (bit i = byte i) as captured in the address cycle, and keeps `mem_we_all_n`=1. Later changes to `cpu_be` or `ram_mode` during the burst have no effect.
- R8: With `ram_mode`=1 captured, each beat drives `mem_we_all_n`=0 and keeps `mem_we_n` all ones.
- R9: `mem_cs_n` is 0 from the first memory beat through the last one and returns to 1 in the next cycle. `mem_oe_n` stays 1 at all times.
- R10: Address-cycle patterns with `cpu_wr`=0 or `cpu_cs_n`=1 start no burst.
- R11: A new address cycle may fall in the same cycle as the memory beat of the previous burst's last word. The new burst then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| cpu_cs_n | input | 1 | Processor chip select, active low |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_be | input | NB | Byte enables, active high, bit i = byte i |
| cpu_last_n | input | 1 | Last word of burst, active low |
| cpu_addr | input | AW | Start word address |
| cpu_wdata | input | DW | Write data |
| ram_mode | input | 1 | 0 = per-byte strobes, 1 = common strobe |
| cpu_rdy_n | output | 1 | Word accepted, active low |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | NB | Per-byte write strobes, active low |
| mem_we_all_n | output | 1 | Common write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, held inactive |

## Verification
Two functions can meet in one cycle. One is the memory beat that carries the last word of a burst. The other is the address cycle of the next burst. The bench starts a second request in exactly the cycle where the first burst's final beat is on the memory port. It checks that the final beat keeps its address, data and strobes. It also checks that chip select is released in the next cycle and that the second burst then runs its arbitration, recovery and data cycles on the normal schedule.

// File: rtl/shmw_pkg.sv
package shmw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_REC  = 2'd2,
    ST_DATA = 2'd3
  } shmw_state_e;

endpackage

// File: rtl/shmw_ctrl.sv
module shmw_ctrl
  import shmw_pkg::*;
#(
  parameter int MAX_BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_as_n,
  input  logic cpu_cs_n,
  input  logic cpu_wr,
  input  logic cpu_last_n,
  output logic start,
  output logic beat
);

  localparam int BW = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam logic [BW-1:0] LAST_BEAT = BW'(MAX_BEATS - 1);

  shmw_state_e state_q, state_d;
  logic [BW-1:0] cnt_q, cnt_d;

  assign start = (state_q == ST_IDLE) && !cpu_as_n && !cpu_cs_n && cpu_wr;
  assign beat  = (state_q == ST_DATA);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_ARB;
      ST_ARB:  state_d = ST_REC;
      ST_REC: begin
        state_d = ST_DATA;
        cnt_d   = '0;
      end
      ST_DATA: begin
        cnt_d = cnt_q + 1'b1;
        if (!cpu_last_n || cnt_q == LAST_BEAT) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/shmw_capture.sv
module shmw_capture #(
  parameter int AW = 17,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          beat,
  input  logic [AW-1:0] cpu_addr,
  input  logic [NB-1:0] cpu_be,
  input  logic          ram_mode,
  output logic [AW-1:0] cur_addr,
  output logic [NB-1:0] be_q,
  output logic          mode_q
);

  logic [AW-1:0] addr_d;
  logic          addr_en;

  assign addr_en = start || beat;
  assign addr_d  = start ? cpu_addr : cur_addr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
    end else if (addr_en) begin
      cur_addr <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q   <= '0;
      mode_q <= 1'b0;
    end else if (start) begin
      be_q   <= cpu_be;
      mode_q <= ram_mode;
    end
  end

endmodule

// File: rtl/shmw_mem_out.sv
module shmw_mem_out #(
  parameter int AW = 17,
  parameter int DW = 32,
  parameter int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [NB-1:0] be_q,
  input  logic          mode_q,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_cs_n,
  output logic [NB-1:0] mem_we_n,
  output logic          mem_we_all_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (beat) begin
      mem_addr  <= cur_addr;
      mem_wdata <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n     <= 1'b1;
      mem_we_all_n <= 1'b1;
    end else begin
      mem_cs_n     <= !beat;
      mem_we_all_n <= !(beat && mode_q);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic strobe_d;
    assign strobe_d = !(beat && !mode_q && be_q[b]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_we_n[b] <= 1'b1;
      else        mem_we_n[b] <= strobe_d;
    end
  end

endmodule

// File: rtl/shmw_top.sv
module shmw_top #(
  parameter int AW        = 17,
  parameter int DW        = 32,
  parameter int NB        = DW / 8,
  parameter int MAX_BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_as_n,
  input  logic          cpu_cs_n,
  input  logic          cpu_wr,
  input  logic [NB-1:0] cpu_be,
  input  logic          cpu_last_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          ram_mode,
  output logic          cpu_rdy_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_cs_n,
  output logic [NB-1:0] mem_we_n,
  output logic          mem_we_all_n,
  output logic          mem_oe_n
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          start, beat;
  logic [AW-1:0] cur_addr;
  logic [NB-1:0] be_q;
  logic          mode_q;

  // reset asserts at once, releases two clocks after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  shmw_ctrl #(.MAX_BEATS(MAX_BEATS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cpu_as_n   (cpu_as_n),
    .cpu_cs_n   (cpu_cs_n),
    .cpu_wr     (cpu_wr),
    .cpu_last_n (cpu_last_n),
    .start      (start),
    .beat       (beat)
  );

  shmw_capture #(.AW(AW), .NB(NB)) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .beat     (beat),
    .cpu_addr (cpu_addr),
    .cpu_be   (cpu_be),
    .ram_mode (ram_mode),
    .cur_addr (cur_addr),
    .be_q     (be_q),
    .mode_q   (mode_q)
  );

  shmw_mem_out #(.AW(AW), .DW(DW), .NB(NB)) u_out (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .beat         (beat),
    .cur_addr     (cur_addr),
    .cpu_wdata    (cpu_wdata),
    .be_q         (be_q),
    .mode_q       (mode_q),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_cs_n     (mem_cs_n),
    .mem_we_n     (mem_we_n),
    .mem_we_all_n (mem_we_all_n)
  );

  assign cpu_rdy_n = !beat;
  assign mem_oe_n  = 1'b1;

endmodule

// File: rtl/shmw_checker.sv
module shmw_checker #(
  parameter int AW        = 17,
  parameter int NB        = 4,
  parameter int MAX_BEATS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_rdy_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic [NB-1:0] mem_we_n,
  input logic          mem_we_all_n,
  input logic          mem_oe_n
);

  localparam int RW = $clog2(MAX_BEATS + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (!mem_cs_n) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n);

  assert_strobe_in_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we_n != {NB{1'b1}}) || !mem_we_all_n) |-> !mem_cs_n);

  assert_mode_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((mem_we_n != {NB{1'b1}}) && !mem_we_all_n));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  assert_rdy_to_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdy_n |=> !mem_cs_n);

  assert_beat_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(MAX_BEATS));

endmodule

bind shmw_top shmw_checker #(.AW(AW), .NB(NB), .MAX_BEATS(MAX_BEATS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_rdy_n    (cpu_rdy_n),
  .mem_addr     (mem_addr),
  .mem_cs_n     (mem_cs_n),
  .mem_we_n     (mem_we_n),
  .mem_we_all_n (mem_we_all_n),
  .mem_oe_n     (mem_oe_n)
);

// File: tb/test_shmw_top.sv
module test_shmw_top;

  localparam int AW = 17;
  localparam int DW = 32;
  localparam int NB = 4;
  localparam int NV = 6;

  // entry: {start addr[16:0], be[3:0], words[2:0], ram_mode}
  localparam logic [24:0] VEC [0:NV-1] = '{
    {17'h00000, 4'hF, 3'd4, 1'b0},
    {17'h00101, 4'hF, 3'd4, 1'b0},
    {17'h00003, 4'h5, 3'd2, 1'b0},
    {17'h0007F, 4'hA, 3'd1, 1'b0},
    {17'h00042, 4'hF, 3'd3, 1'b1},
    {17'h00010, 4'h3, 3'd6, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_as_n = 1'b1, cpu_cs_n = 1'b1, cpu_wr = 1'b0, cpu_last_n = 1'b1;
  logic [NB-1:0] cpu_be = '0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          ram_mode = 1'b0;
  logic          cpu_rdy_n, mem_cs_n, mem_we_all_n, mem_oe_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [NB-1:0] mem_we_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shmw_top i_shmw_top (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_cs_n(cpu_cs_n),
    .cpu_wr(cpu_wr), .cpu_be(cpu_be), .cpu_last_n(cpu_last_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ram_mode(ram_mode),
    .cpu_rdy_n(cpu_rdy_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_we_all_n(mem_we_all_n),
    .mem_oe_n(mem_oe_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int seed, input int i);
    return (32'hA5000000 + 32'(seed)) ^ (32'(i) * 32'h01010101);
  endfunction

  task automatic check_idle_outputs(input string req);
    chk(req, {cpu_rdy_n, mem_cs_n, mem_we_n, mem_we_all_n, mem_oe_n},
        {1'b1, 1'b1, 4'hF, 1'b1, 1'b1});
  endtask

  task automatic check_beat(input logic [AW-1:0] a, input int j, input logic [3:0] be,
                            input bit mode, input int seed);
    chk("R9 cs during beat", mem_cs_n, 1'b0);
    chk("R6 beat address", mem_addr, a + AW'(j));
    chk("R5 beat data", mem_wdata, word_of(seed, j));
    if (mode) chk("R8 common strobe", {mem_we_n, mem_we_all_n}, {4'hF, 1'b0});
    else      chk("R7 byte strobes", {mem_we_n, mem_we_all_n}, {~be, 1'b1});
    chk("R9 oe inactive", mem_oe_n, 1'b1);
  endtask

  task automatic drive_addr_cycle(input logic [AW-1:0] a, input logic [3:0] be, input bit mode);
    cpu_as_n = 1'b0; cpu_cs_n = 1'b0; cpu_wr = 1'b1;
    cpu_addr = a; cpu_be = be; ram_mode = mode;
  endtask

  // skip: address cycle already driven; chain: start next burst at last beat
  task automatic run_burst(input logic [AW-1:0] a, input logic [3:0] be, input int n,
                           input bit mode, input int seed, input bit skip,
                           input bit chain, input logic [AW-1:0] na,
                           input logic [3:0] nbe, input bit nmode);
    int nb;
    nb = (n > 4) ? 4 : n;
    if (!skip) begin
      @(negedge clk);
      drive_addr_cycle(a, be, mode);
    end
    @(negedge clk);
    if (skip) chk("R11 prior burst released", {mem_cs_n, mem_we_n, mem_we_all_n}, {1'b1, 4'hF, 1'b1});
    cpu_as_n = 1'b1; cpu_cs_n = 1'b1;
    cpu_be = ~be; ram_mode = ~mode;  // later changes must be ignored (R7)
    chk("R2 no ready in arbitration", cpu_rdy_n, 1'b1);
    @(negedge clk);
    chk("R2 no ready in recovery", cpu_rdy_n, 1'b1);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      if (i > 0) check_beat(a, i - 1, be, mode, seed);
      chk("R3 ready each word", cpu_rdy_n, 1'b0);
      cpu_wdata  = word_of(seed, i);
      cpu_last_n = (i == n - 1) ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    check_beat(a, nb - 1, be, mode, seed);
    chk("R4 ready ends after final word", cpu_rdy_n, 1'b1);
    cpu_last_n = 1'b1;
    if (chain) drive_addr_cycle(na, nbe, nmode);
    else begin
      @(negedge clk);
      chk("R9 cs released after burst", {mem_cs_n, mem_we_n, mem_we_all_n}, {1'b1, 4'hF, 1'b1});
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check_idle_outputs("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle_outputs("R1 after reset");

    for (int v = 0; v < NV; v++) begin
      run_burst(VEC[v][24:8], VEC[v][7:4], int'(VEC[v][3:1]), VEC[v][0], v,
                1'b0, 1'b0, '0, '0, 1'b0);
    end

    // R10: read direction and deselected strobe start nothing
    @(negedge clk);
    cpu_as_n = 1'b0; cpu_cs_n = 1'b0; cpu_wr = 1'b0; cpu_be = 4'hF;
    @(negedge clk);
    cpu_cs_n = 1'b1; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_as_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R10 ignored request", {cpu_rdy_n, mem_cs_n}, 2'b11);
    end

    // R11: next address cycle coincides with the final memory beat
    run_burst(17'h00201, 4'hF, 2, 1'b0, 20, 1'b0, 1'b1, 17'h00302, 4'h9, 1'b1);
    run_burst(17'h00302, 4'h9, 3, 1'b1, 21, 1'b1, 1'b0, '0, '0, 1'b0);

    // R1: reset in the middle of a burst
    @(negedge clk);
    drive_addr_cycle(17'h00400, 4'hF, 1'b0);
    @(negedge clk);
    cpu_as_n = 1'b1; cpu_cs_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle_outputs("R1 reset mid-burst");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle_outputs("R1 idle after mid-burst reset");
    run_burst(17'h00503, 4'hC, 4, 1'b0, 30, 1'b0, 1'b0, '0, '0, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule